// File: doc/BRIEF.md
# Serial Audio Receive Clock Generator

This block makes the two receive-side clocks of a serial audio port. A fast master clock is made either by dividing the auxiliary clock by a programmable ratio or by passing through an externally driven master clock pin. A bit clock is then made either by dividing that master clock a second time or by passing through an externally driven bit clock pin. Each clock has its own inversion control, and each clock pin has an output enable. The enable is raised only when the block drives that clock itself.

A synchronous option ties the receiver to the transmitter. When the receive-asynchronous control is low, the receive bit clock output is the transmit bit clock, and the receive selection and divider settings have no effect on it. All sequential logic runs on the auxiliary clock. The external master clock is brought into that domain through a synchronizer and a rising-edge detector, and the result steps the bit divider.

Each divider holds its active ratio and source choice until it reaches its terminal count. A new setting written in the middle of a period therefore only takes effect at the start of the next full period, so no pulse is ever cut short. The block has no streaming data path, so all of its pins are plain level controls and clocks.

Top module: `rx_clkgen`

## Requirements
- R1: With the high-clock mode active as internal and ratio field N (12 bits), hclk_o has a period of N+1 auxiliary clock cycles, and N=0 makes hclk_o follow aux_clk itself.
- R2: A divided clock with an even ratio is high for exactly half the period. With an odd ratio, the high phase is one source cycle longer than the low phase.
- R3: With the high-clock mode active as external, hclk_o follows hclk_pin_i.
- R4: hclk_inv_i=1 inverts hclk_o, both for the internal source and for the external source.
- R5: With the bit-clock mode active as internal and ratio field M (5 bits), the bit clock period is M+1 rising edges of the un-inverted master clock. This holds whether the master clock is internal or comes from the pin.
- R6: With the bit-clock mode active as external, the bit clock follows bclk_pin_i. bclk_inv_i=1 inverts the bit clock for either source.
- R7: When rx_async_i=0, bclk_o equals tx_bclk_i, bclk_oe_o is 0, and the bit-clock mode, ratio and inversion controls have no effect on bclk_o.
- R8: A change to a ratio or mode field takes effect only when the divider next reaches its terminal count. The period that is running completes at its old length. The first terminal count after reset falls on the first source edge.
- R9: hclk_oe_o is 1 exactly when the active high-clock mode is internal. bclk_oe_o is 1 exactly when the active bit-clock mode is internal and rx_async_i=1. During reset, both active modes are external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aux_clk | input | 1 | Auxiliary clock, source of the internal master clock and clock of all registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| hclk_pin_i | input | 1 | External master clock pin level |
| bclk_pin_i | input | 1 | External bit clock pin level |
| tx_bclk_i | input | 1 | Transmit bit clock, used in synchronous mode |
| hclk_int_i | input | 1 | 1 = master clock generated internally |
| hclk_inv_i | input | 1 | 1 = invert master clock output |
| hclk_div_i | input | 12 | Master clock ratio minus one |
| bclk_int_i | input | 1 | 1 = bit clock generated internally |
| bclk_inv_i | input | 1 | 1 = invert bit clock output |
| bclk_div_i | input | 5 | Bit clock ratio minus one |
| rx_async_i | input | 1 | 0 = receive bit clock taken from transmit bit clock |
| hclk_o | output | 1 | Receive master clock |
| bclk_o | output | 1 | Receive bit clock |
| hclk_oe_o | output | 1 | Master clock pin output enable |
| bclk_oe_o | output | 1 | Bit clock pin output enable |

## Verification
Odd ratios are measured phase by phase, because a divider that splits the period by truncating the half would make the low phase the longer one. A ratio change is made just after a rising edge, with a ratio of one hundred, so that a divider that reloads at once would show a short high phase instead of the expected fifty cycles. The chain from the external master pin into the bit divider is run with a slow pin clock, which catches a tick taken from the wrong edge or from the raw pin. Synchronous mode is driven with the inversion bit set, to expose any design that inverts the transmit clock or leaves the bit pin enabled.

// File: rtl/rx_clk_pkg.sv
`timescale 1ns/1ps
package rx_clk_pkg;
  localparam int HDIV_W_DEF = 12;
  localparam int BDIV_W_DEF = 5;
  localparam int SYNC_STAGES_DEF = 2;

  // Number of source cycles in the high phase for a ratio of n+1.
  function automatic int high_len(input int n);
    return (n + 2) / 2;
  endfunction
endpackage

// File: rtl/rxcg_edge_sync.sv
`timescale 1ns/1ps
module rxcg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= pin_i;
  end

  genvar gi;
  generate
    for (gi = 1; gi <= LAST; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[gi] <= 1'b0;
        else        chain_q[gi] <= chain_q[gi-1];
      end
    end
  endgenerate

  assign rise_o = chain_q[LAST-1] & ~chain_q[LAST];
endmodule

// File: rtl/rxcg_divider.sv
`timescale 1ns/1ps
module rxcg_divider
  import rx_clk_pkg::*;
#(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         src_level_i,
  input  logic [W-1:0] div_i,
  input  logic         mode_i,
  output logic         level_o,
  output logic         rise_next_o,
  output logic         mode_act_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] lim_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim_q;
  logic         phase_q;
  logic         mode_q;
  logic         at_term;
  logic         next_high;

  assign at_term   = (cnt_q == lim_q);
  assign next_high = (int'(cnt_q) + 1) < high_len(int'(lim_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      lim_q   <= '0;
      phase_q <= 1'b0;
      mode_q  <= 1'b0;
    end else if (tick_i) begin
      if (at_term) begin
        cnt_q   <= '0;
        lim_q   <= div_i;
        mode_q  <= mode_i;
        phase_q <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        phase_q <= next_high;
      end
    end
  end

  assign level_o     = (lim_q == '0) ? src_level_i : phase_q;
  assign rise_next_o = tick_i & at_term;
  assign mode_act_o  = mode_q;
  assign cnt_o       = cnt_q;
  assign lim_o       = lim_q;
endmodule

// File: rtl/rx_clkgen.sv
`timescale 1ns/1ps
module rx_clkgen
  import rx_clk_pkg::*;
#(
  parameter int HDIV_W      = HDIV_W_DEF,
  parameter int BDIV_W      = BDIV_W_DEF,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              aux_clk,
  input  logic              rst_n,
  input  logic              hclk_pin_i,
  input  logic              bclk_pin_i,
  input  logic              tx_bclk_i,
  input  logic              hclk_int_i,
  input  logic              hclk_inv_i,
  input  logic [HDIV_W-1:0] hclk_div_i,
  input  logic              bclk_int_i,
  input  logic              bclk_inv_i,
  input  logic [BDIV_W-1:0] bclk_div_i,
  input  logic              rx_async_i,
  output logic              hclk_o,
  output logic              bclk_o,
  output logic              hclk_oe_o,
  output logic              bclk_oe_o
);
  // master clock divider, stepped on every auxiliary cycle
  logic              h_level, h_rise, h_mode;
  logic [HDIV_W-1:0] h_cnt, h_lim;

  rxcg_divider #(.W(HDIV_W)) u_hdiv (
    .clk        (aux_clk),
    .rst_n      (rst_n),
    .tick_i     (1'b1),
    .src_level_i(aux_clk),
    .div_i      (hclk_div_i),
    .mode_i     (hclk_int_i),
    .level_o    (h_level),
    .rise_next_o(h_rise),
    .mode_act_o (h_mode),
    .cnt_o      (h_cnt),
    .lim_o      (h_lim)
  );

  // external master clock brought into the auxiliary domain
  logic ext_h_rise;

  rxcg_edge_sync #(.STAGES(SYNC_STAGES)) u_hsync (
    .clk   (aux_clk),
    .rst_n (rst_n),
    .pin_i (hclk_pin_i),
    .rise_o(ext_h_rise)
  );

  logic hclk_raw;
  logic b_tick;

  assign hclk_raw = h_mode ? h_level : hclk_pin_i;
  assign b_tick   = h_mode ? h_rise  : ext_h_rise;

  // bit clock divider, stepped on master clock rising edges
  logic              b_level, b_rise, b_mode;
  logic [BDIV_W-1:0] b_cnt, b_lim;

  rxcg_divider #(.W(BDIV_W)) u_bdiv (
    .clk        (aux_clk),
    .rst_n      (rst_n),
    .tick_i     (b_tick),
    .src_level_i(hclk_raw),
    .div_i      (bclk_div_i),
    .mode_i     (bclk_int_i),
    .level_o    (b_level),
    .rise_next_o(b_rise),
    .mode_act_o (b_mode),
    .cnt_o      (b_cnt),
    .lim_o      (b_lim)
  );

  logic bclk_own;

  assign bclk_own  = (b_mode ? b_level : bclk_pin_i) ^ bclk_inv_i;
  assign hclk_o    = hclk_raw ^ hclk_inv_i;
  assign bclk_o    = rx_async_i ? bclk_own : tx_bclk_i;
  assign hclk_oe_o = h_mode;
  assign bclk_oe_o = b_mode & rx_async_i;
endmodule

// File: rtl/rx_clkgen_checker.sv
`timescale 1ns/1ps
module rx_clkgen_checker #(
  parameter int HDIV_W = 12,
  parameter int BDIV_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hclk_int,
  input logic              rx_async,
  input logic              tx_bclk,
  input logic              bclk_out,
  input logic              hclk_oe,
  input logic              h_level,
  input logic              h_mode,
  input logic [HDIV_W-1:0] h_cnt,
  input logic [HDIV_W-1:0] h_lim,
  input logic              b_tick,
  input logic [BDIV_W-1:0] b_cnt,
  input logic [BDIV_W-1:0] b_lim
);
  // R7: synchronous mode hands the transmit clock straight through
  a_r7_sync_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_async |-> (bclk_out == tx_bclk));

  // R8: counters never pass their active limit
  a_r8_hcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    h_cnt <= h_lim);
  a_r8_bcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    b_cnt <= b_lim);

  // R8: active limits only move at a terminal count
  a_r8_hlim_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt != h_lim) |=> $stable(h_lim));
  a_r8_blim_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_tick || (b_cnt != b_lim)) |=> $stable(b_lim));

  // R2: with ratio three or more the high phase lasts at least two cycles
  a_r2_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(h_level) && h_lim >= 2) |=> h_level);

  // R9: the master pin enable can only rise after internal mode was requested
  a_r9_hoe_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hclk_oe) |-> $past(hclk_int));
  a_r9_hoe_mode: assert property (@(posedge clk) disable iff (!rst_n)
    hclk_oe == h_mode);
endmodule

bind rx_clkgen rx_clkgen_checker #(.HDIV_W(HDIV_W), .BDIV_W(BDIV_W)) u_chk (
  .clk     (aux_clk),
  .rst_n   (rst_n),
  .hclk_int(hclk_int_i),
  .rx_async(rx_async_i),
  .tx_bclk (tx_bclk_i),
  .bclk_out(bclk_o),
  .hclk_oe (hclk_oe_o),
  .h_level (h_level),
  .h_mode  (h_mode),
  .h_cnt   (h_cnt),
  .h_lim   (h_lim),
  .b_tick  (b_tick),
  .b_cnt   (b_cnt),
  .b_lim   (b_lim)
);

// File: tb/test_rx_clkgen.sv
`timescale 1ns/1ps
module test_rx_clkgen;
  logic aux_clk = 1'b0;
  logic rst_n = 1'b0;
  logic hpin_static = 1'b0;
  logic ext_run = 1'b0;
  logic ext_tog = 1'b0;
  logic hclk_pin_i;
  logic bclk_pin_i = 1'b0;
  logic tx_bclk_i = 1'b0;
  logic hclk_int_i = 1'b0;
  logic hclk_inv_i = 1'b0;
  logic [11:0] hclk_div_i = '0;
  logic bclk_int_i = 1'b0;
  logic bclk_inv_i = 1'b0;
  logic [4:0] bclk_div_i = '0;
  logic rx_async_i = 1'b1;
  logic hclk_o, bclk_o, hclk_oe_o, bclk_oe_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 aux_clk = ~aux_clk;

  assign hclk_pin_i = ext_run ? ext_tog : hpin_static;

  rx_clkgen i_rx_clkgen (
    .aux_clk   (aux_clk),
    .rst_n     (rst_n),
    .hclk_pin_i(hclk_pin_i),
    .bclk_pin_i(bclk_pin_i),
    .tx_bclk_i (tx_bclk_i),
    .hclk_int_i(hclk_int_i),
    .hclk_inv_i(hclk_inv_i),
    .hclk_div_i(hclk_div_i),
    .bclk_int_i(bclk_int_i),
    .bclk_inv_i(bclk_inv_i),
    .bclk_div_i(bclk_div_i),
    .rx_async_i(rx_async_i),
    .hclk_o    (hclk_o),
    .bclk_o    (bclk_o),
    .hclk_oe_o (hclk_oe_o),
    .bclk_oe_o (bclk_oe_o)
  );

  // external master clock: toggles every 4 auxiliary cycles
  initial begin
    forever begin
      repeat (4) @(negedge aux_clk);
      ext_tog = ~ext_tog;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge aux_clk);
    #2;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) step();
  endtask

  function automatic logic sig(input int s);
    return (s == 0) ? hclk_o : bclk_o;
  endfunction

  task automatic wait_rise(input int s);
    int g = 0;
    step();
    while (sig(s) !== 1'b0 && g < 3000) begin step(); g++; end
    while (sig(s) !== 1'b1 && g < 3000) begin step(); g++; end
  endtask

  task automatic count_phase(input int s, output int hi, output int lo);
    int g = 0;
    hi = 0;
    lo = 0;
    while (sig(s) === 1'b1 && g < 3000) begin hi++; step(); g++; end
    while (sig(s) === 1'b0 && g < 3000) begin lo++; step(); g++; end
  endtask

  task automatic measure(input int s, output int hi, output int lo);
    wait_rise(s);
    count_phase(s, hi, lo);
  endtask

  task automatic t_reset();
    hpin_static = 1'b1;
    bclk_pin_i  = 1'b1;
    hclk_int_i  = 1'b1;
    bclk_int_i  = 1'b1;
    wait_cycles(3);
    check(hclk_oe_o === 1'b0, "R9 reset hclk_oe", int'(hclk_oe_o), 0);
    check(bclk_oe_o === 1'b0, "R9 reset bclk_oe", int'(bclk_oe_o), 0);
    check(hclk_o === 1'b1, "R3 reset hclk follows pin", int'(hclk_o), 1);
    check(bclk_o === 1'b1, "R6 reset bclk follows pin", int'(bclk_o), 1);
    hpin_static = 1'b0;
    bclk_pin_i  = 1'b0;
    bclk_int_i  = 1'b0;
    @(negedge aux_clk);
    rst_n = 1'b1;
  endtask

  task automatic t_hdiv();
    int hi, lo;
    hclk_div_i = 12'd3;
    wait_cycles(20);
    check(hclk_oe_o === 1'b1, "R9 hclk_oe internal", int'(hclk_oe_o), 1);
    measure(0, hi, lo);
    check(hi == 2, "R1 ratio4 high", hi, 2);
    check(lo == 2, "R2 ratio4 low", lo, 2);
    hclk_div_i = 12'd4;
    wait_cycles(20);
    measure(0, hi, lo);
    check(hi == 3, "R2 ratio5 high", hi, 3);
    check(lo == 2, "R2 ratio5 low", lo, 2);
    hclk_div_i = 12'd0;
    wait_cycles(20);
    for (int k = 0; k < 3; k++) begin
      @(posedge aux_clk); #1;
      check(hclk_o === 1'b1, "R1 pass high half", int'(hclk_o), 1);
      @(negedge aux_clk); #1;
      check(hclk_o === 1'b0, "R1 pass low half", int'(hclk_o), 0);
    end
  endtask

  task automatic t_hinv();
    int hi, lo;
    hclk_div_i = 12'd4;
    hclk_inv_i = 1'b1;
    wait_cycles(20);
    measure(0, hi, lo);
    check(hi == 2, "R4 inverted high", hi, 2);
    check(lo == 3, "R4 inverted low", lo, 3);
    hclk_int_i  = 1'b0;
    hpin_static = 1'b0;
    wait_cycles(20);
    check(hclk_o === 1'b1, "R4 external inverted", int'(hclk_o), 1);
    check(hclk_oe_o === 1'b0, "R9 hclk_oe external", int'(hclk_oe_o), 0);
    hpin_static = 1'b1;
    wait_cycles(1);
    check(hclk_o === 1'b0, "R4 external inverted", int'(hclk_o), 0);
    hclk_inv_i  = 1'b0;
    wait_cycles(1);
    check(hclk_o === 1'b1, "R3 external follow", int'(hclk_o), 1);
    hpin_static = 1'b0;
  endtask

  task automatic t_bdiv();
    int hi, lo;
    hclk_int_i = 1'b1;
    hclk_div_i = 12'd1;
    bclk_int_i = 1'b1;
    bclk_div_i = 5'd2;
    rx_async_i = 1'b1;
    wait_cycles(40);
    check(bclk_oe_o === 1'b1, "R9 bclk_oe internal", int'(bclk_oe_o), 1);
    measure(1, hi, lo);
    check(hi == 4, "R5 bit ratio3 high", hi, 4);
    check(lo == 2, "R5 bit ratio3 low", lo, 2);
    bclk_inv_i = 1'b1;
    wait_cycles(6);
    measure(1, hi, lo);
    check(hi == 2, "R6 bit inverted high", hi, 2);
    check(lo == 4, "R6 bit inverted low", lo, 4);
  endtask

  task automatic t_bext();
    bclk_int_i = 1'b0;
    bclk_pin_i = 1'b1;
    wait_cycles(40);
    check(bclk_o === 1'b0, "R6 external inverted", int'(bclk_o), 0);
    check(bclk_oe_o === 1'b0, "R9 bclk_oe external", int'(bclk_oe_o), 0);
    bclk_inv_i = 1'b0;
    wait_cycles(1);
    check(bclk_o === 1'b1, "R6 external follow", int'(bclk_o), 1);
    bclk_pin_i = 1'b0;
    wait_cycles(1);
    check(bclk_o === 1'b0, "R6 external follow", int'(bclk_o), 0);
  endtask

  task automatic t_sync();
    bclk_int_i = 1'b1;
    bclk_inv_i = 1'b1;
    wait_cycles(40);
    rx_async_i = 1'b0;
    tx_bclk_i  = 1'b1;
    wait_cycles(1);
    check(bclk_o === 1'b1, "R7 sync follow tx", int'(bclk_o), 1);
    check(bclk_oe_o === 1'b0, "R7 sync bclk_oe", int'(bclk_oe_o), 0);
    for (int k = 0; k < 5; k++) begin
      tx_bclk_i = ~tx_bclk_i;
      wait_cycles(1);
      check(bclk_o === tx_bclk_i, "R7 sync follow tx", int'(bclk_o), int'(tx_bclk_i));
    end
    rx_async_i = 1'b1;
    bclk_inv_i = 1'b0;
  endtask

  task automatic t_ext_src();
    int hi, lo;
    hclk_int_i = 1'b0;
    bclk_int_i = 1'b1;
    bclk_div_i = 5'd1;
    ext_run    = 1'b1;
    wait_cycles(80);
    measure(0, hi, lo);
    check(hi == 4 && lo == 4, "R3 pin clock through", hi * 100 + lo, 404);
    measure(1, hi, lo);
    check(hi == 8, "R5 from pin high", hi, 8);
    check(lo == 8, "R5 from pin low", lo, 8);
    ext_run = 1'b0;
  endtask

  task automatic t_retime();
    int hi, lo;
    hclk_int_i = 1'b1;
    hclk_div_i = 12'd99;
    wait_cycles(250);
    wait_rise(0);
    hclk_div_i = 12'd1;
    count_phase(0, hi, lo);
    check(hi == 50, "R8 old period high kept", hi, 50);
    check(lo == 50, "R8 old period low kept", lo, 50);
    count_phase(0, hi, lo);
    check(hi == 1 && lo == 1, "R8 new ratio after wrap", hi * 100 + lo, 101);
    hclk_div_i = 12'd99;
    wait_cycles(250);
    wait_rise(0);
    hclk_int_i = 1'b0;
    wait_cycles(30);
    check(hclk_oe_o === 1'b1, "R8 mode held until wrap", int'(hclk_oe_o), 1);
    wait_cycles(100);
    check(hclk_oe_o === 1'b0, "R9 mode applied after wrap", int'(hclk_oe_o), 0);
  endtask

  initial begin
    t_reset();
    t_hdiv();
    t_hinv();
    t_bdiv();
    t_bext();
    t_sync();
    t_ext_src();
    t_retime();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule